// File: doc/BRIEF.md
# Dual-Range Epoch Counter Pair

This block keeps two chained epoch counts for one receiver channel: a fast count that steps once per dump strobe and wraps every 20 dumps, and a slow count that steps each time the fast count wraps and itself wraps every 50 steps. Software sets both counts through one 16-bit write port. The timing of that setting depends on the channel mode. In update mode the written values take effect at once. In preset mode the write only stores the values and arms a transfer, and the transfer happens at the next tic strobe.

Two read words are offered. The snapshot word holds both counts as they stood at the most recent tic. The live word follows the counters cycle by cycle, so it can change under a reader on any dump. The dump and tic strobes come from elsewhere in the channel.

Top module: `epoch_pair`

## Requirements
- R1: After reset, and after any later reset pulse, both read words are zero and no preset transfer is pending.
- R2: Each cycle with `dump_i` high and no load advances the fast count by one, wrapping from 19 to 0. With no dump, write or tic, the live word holds its value.
- R3: When the fast count wraps from 19 to 0, the slow count advances by one and wraps from 49 to 0.
- R4: Both read words carry the slow count in bits 13:8 and the fast count in bits 4:0. Bits 15, 14, 7, 6 and 5 always read zero.
- R5: A tic copies the counts as they stood before that clock edge into the snapshot word, ignoring any load or dump in the same cycle. Without a tic the snapshot word holds its value.
- R6: In update mode (`preset_mode_i` = 0), a write (`wr_en_i` high, slow value in `wr_data_i[13:8]`, fast value in `wr_data_i[4:0]`) appears on the live word in the next cycle and overrides a dump in the same cycle.
- R7: In preset mode (`preset_mode_i` = 1), a write leaves the counters untouched and arms a transfer. The transfer loads the stored values at the first tic in a later cycle. A tic in the same cycle as the write does not fire it.
- R8: When a preset transfer and a dump fall in the same cycle, the loaded values win over the increment.
- R9: A written fast value is reduced modulo 20 and a written slow value modulo 50 before it is stored. For example, 31 becomes 11 and 63 becomes 13.
- R10: A preset transfer fires once. Later tics with no new preset write do not load the counters again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dump_i | input | 1 | Dump strobe, one cycle per dump |
| tic_i | input | 1 | Tic strobe, one cycle per tic |
| preset_mode_i | input | 1 | 1 = preset mode (deferred load), 0 = update mode (immediate load) |
| wr_en_i | input | 1 | Write strobe for the load word |
| wr_data_i | input | 16 | Load word: slow count in 13:8, fast count in 4:0 |
| snap_o | output | 16 | Counts captured at the last tic |
| live_o | output | 16 | Current counts, not latched |

## Verification
The bench builds the block with its default moduli of 20 and 50. With these values, full wraps of both counts, including the double wrap from (49,19) to (0,0), fit in a single dump step. The 5- and 6-bit fields also leave room for out-of-range writes such as 31 and 63, which exercise the modulo reduction. Collisions of write, tic and dump in one cycle are driven on purpose, covering load priority, the pre-edge tic sample and a preset that a same-cycle tic must not fire.

// File: rtl/epoch_pkg.sv
// Shared field layout and word packing for the epoch counter pair.
// Assumes the fast count fits in 5 bits and the slow count in 6 bits.
package epoch_pkg;
    localparam int WORD_W  = 16;
    localparam int FAST_FW = 5;
    localparam int SLOW_FW = 6;
    localparam int FAST_LSB = 0;
    localparam int SLOW_LSB = 8;

    // Build a read word: slow count in 13:8, fast count in 4:0, rest zero.
    function automatic logic [WORD_W-1:0] pack_word(input logic [SLOW_FW-1:0] slow,
                                                    input logic [FAST_FW-1:0] fast);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SLOW_LSB +: SLOW_FW] = slow;
        w[FAST_LSB +: FAST_FW] = fast;
        return w;
    endfunction
endpackage

// File: rtl/epoch_mod_counter.sv
// Modulo-MOD counter with a synchronous load that has priority over the
// increment. wrap_o flags the cycle in which an increment turns MOD-1 into 0.
// Assumes ld_val_i is already below MOD.
module epoch_mod_counter #(
    parameter int MOD = 20,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    // Wrap indication for the next stage in the chain.
    assign wrap_o = inc_i && (cnt_o == TOP);

    // Count register: reset, load, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (ld_i) begin
            cnt_o <= ld_val_i;
        end else if (inc_i) begin
            cnt_o <= (cnt_o == TOP) ? '0 : cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/epoch_preset_hold.sv
// Holds load values written in preset mode and fires one transfer at the
// first tic after the write cycle. A write and a tic in the same cycle arm
// only; the older pending values, if any, are what fire in that cycle.
module epoch_preset_hold #(
    parameter int FAST_W = 5,
    parameter int SLOW_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [FAST_W-1:0] fast_i,
    input  logic [SLOW_W-1:0] slow_i,
    input  logic              tic_i,
    output logic              fire_o,
    output logic [FAST_W-1:0] fast_o,
    output logic [SLOW_W-1:0] slow_o
);
    logic armed_q;

    // A transfer fires only when armed in an earlier cycle.
    assign fire_o = armed_q && tic_i;

    // Arm flag and pending values: a new write re-arms, a fired transfer clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            fast_o  <= '0;
            slow_o  <= '0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
            fast_o  <= fast_i;
            slow_o  <= slow_i;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/epoch_pair.sv
// Epoch counter pair for one channel: a fast count stepped by dumps and a
// slow count stepped by the fast count's wrap. Writes load at once in update
// mode or arm a tic-timed transfer in preset mode. A tic snapshots the
// pre-edge counts. Assumes MOD values fit the 5- and 6-bit word fields.
module epoch_pair #(
    parameter int FAST_MOD = 20,
    parameter int SLOW_MOD = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dump_i,
    input  logic        tic_i,
    input  logic        preset_mode_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] snap_o,
    output logic [15:0] live_o
);
    import epoch_pkg::*;

    localparam int FAST_W = $clog2(FAST_MOD);
    localparam int SLOW_W = $clog2(SLOW_MOD);

    logic [FAST_W-1:0] fast_req, fast_pend, fast_ld, fast_cnt;
    logic [SLOW_W-1:0] slow_req, slow_pend, slow_ld, slow_cnt;
    logic              upd_wr, pre_wr, pre_fire, any_ld, fast_wrap, slow_wrap;

    // Reduce the written fields into their valid ranges.
    assign fast_req = FAST_W'(32'(wr_data_i[FAST_LSB +: FAST_FW]) % FAST_MOD);
    assign slow_req = SLOW_W'(32'(wr_data_i[SLOW_LSB +: SLOW_FW]) % SLOW_MOD);

    // Route a write by mode.
    assign upd_wr = wr_en_i && !preset_mode_i;
    assign pre_wr = wr_en_i &&  preset_mode_i;

    epoch_preset_hold #(
        .FAST_W (FAST_W),
        .SLOW_W (SLOW_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (pre_wr),
        .fast_i (fast_req),
        .slow_i (slow_req),
        .tic_i  (tic_i),
        .fire_o (pre_fire),
        .fast_o (fast_pend),
        .slow_o (slow_pend)
    );

    // Pick the load source; the newer immediate write wins over a firing preset.
    always_comb begin
        any_ld  = upd_wr || pre_fire;
        fast_ld = upd_wr ? fast_req : fast_pend;
        slow_ld = upd_wr ? slow_req : slow_pend;
    end

    epoch_mod_counter #(
        .MOD (FAST_MOD),
        .W   (FAST_W)
    ) u_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (dump_i),
        .ld_i     (any_ld),
        .ld_val_i (fast_ld),
        .cnt_o    (fast_cnt),
        .wrap_o   (fast_wrap)
    );

    epoch_mod_counter #(
        .MOD (SLOW_MOD),
        .W   (SLOW_W)
    ) u_slow (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (fast_wrap),
        .ld_i     (any_ld),
        .ld_val_i (slow_ld),
        .cnt_o    (slow_cnt),
        .wrap_o   (slow_wrap)
    );

    // Live view of the counters.
    assign live_o = pack_word(SLOW_FW'(slow_cnt), FAST_FW'(fast_cnt));

    // Snapshot register: takes the pre-edge counts on each tic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_o <= '0;
        end else if (tic_i) begin
            snap_o <= live_o;
        end
    end

    // The slow wrap has no consumer in this block.
    logic unused_ok;
    assign unused_ok = slow_wrap;
endmodule

// File: rtl/epoch_pair_chk.sv
// Property checker for epoch_pair, attached to every instance by bind.
module epoch_pair_chk #(
    parameter int FAST_MOD = 20,
    parameter int SLOW_MOD = 50
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dump_i,
    input logic        tic_i,
    input logic        preset_mode_i,
    input logic        wr_en_i,
    input logic [15:0] wr_data_i,
    input logic [15:0] snap_o,
    input logic [15:0] live_o
);
    // R4
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_o & 16'hC0E0) == 16'h0) && ((snap_o & 16'hC0E0) == 16'h0));

    // R9
    live_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(live_o[4:0]) < FAST_MOD) && (32'(live_o[13:8]) < SLOW_MOD));

    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dump_i && !wr_en_i && !tic_i) |=> $stable(live_o));

    // R5
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tic_i |=> (snap_o == $past(live_o)));

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tic_i |=> $stable(snap_o));

    // R6
    update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !preset_mode_i) |=>
        (32'(live_o[4:0]) == 32'($past(wr_data_i[4:0])) % FAST_MOD));

    // R7
    preset_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && preset_mode_i && !dump_i && !tic_i) |=> $stable(live_o));
endmodule

bind epoch_pair epoch_pair_chk #(
    .FAST_MOD (FAST_MOD),
    .SLOW_MOD (SLOW_MOD)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dump_i        (dump_i),
    .tic_i         (tic_i),
    .preset_mode_i (preset_mode_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .snap_o        (snap_o),
    .live_o        (live_o)
);

// File: tb/epoch_pair_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// reset tests.
module epoch_pair_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    typedef struct packed {
        logic        dump;
        logic        tic;
        logic        wr;
        logic        mode;
        logic [15:0] data;
        logic [15:0] exp_live;
        logic [15:0] exp_snap;
        logic [3:0]  req;
    } vec_t;

    // Words written as {slow,fast}: 0x0312 is slow 3, fast 18.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0312, 16'h0312, 16'h0000, 4'd6},  // R6 update load
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0313, 16'h0000, 4'd2},  // R2 step
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0400, 16'h0000, 4'd3},  // R3 fast wrap
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0400, 16'h0400, 4'd5},  // R5 snapshot
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0401, 16'h0400, 4'd5},  // R5 pre-edge sample
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'h3113, 16'h3113, 16'h0400, 4'd6},  // R6 load beats dump
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0400, 4'd3},  // R3 double wrap
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0A05, 16'h0000, 16'h0400, 4'd7},  // R7 deferred
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0001, 16'h0400, 4'd7},  // R7 still deferred
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0A05, 16'h0001, 4'd8},  // R8 preset beats dump
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0A06, 16'h0001, 4'd2},  // R2 step after preset
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0A06, 16'h0A06, 4'd10}, // R10 no reload
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0D0B, 16'h0A06, 4'd9},  // R9 reduce 31,63
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h1402, 16'h0D0B, 16'h0D0B, 4'd7},  // R7 same-cycle tic
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h1402, 16'h0D0B, 4'd7},  // R7 later tic fires
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1403, 16'h0D0B, 4'd2}   // R2 step
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dump_i = 1'b0;
    logic        tic_i = 1'b0;
    logic        preset_mode_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] snap_o, live_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    epoch_pair uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dump_i        (dump_i),
        .tic_i         (tic_i),
        .preset_mode_i (preset_mode_i),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .snap_o        (snap_o),
        .live_o        (live_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, let the edge pass, then return to idle.
    task automatic step(input logic d, input logic t, input logic w, input logic m,
                        input logic [15:0] data);
        dump_i = d; tic_i = t; wr_en_i = w; preset_mode_i = m; wr_data_i = data;
        @(posedge clk);
        #1;
        dump_i = 1'b0; tic_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 live after reset", live_o, 16'h0000);
        check("R1 snap after reset", snap_o, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].dump, VEC[i].tic, VEC[i].wr, VEC[i].mode, VEC[i].data);
            check($sformatf("R%0d vec%0d live", VEC[i].req, i), live_o, VEC[i].exp_live);
            check($sformatf("R%0d vec%0d snap", VEC[i].req, i), snap_o, VEC[i].exp_snap);
            // R4 unused bits read zero
            check($sformatf("R4 vec%0d unused bits", i),
                  (live_o | snap_o) & 16'hC0E0, 16'h0000);
        end

        // R1 reset pulse clears counts, snapshot and a pending preset
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'h0507);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
        check("R1 live after mid reset", live_o, 16'h0000);
        check("R1 snap after mid reset", snap_o, 16'h0000);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);
        check("R1 no pending preset after reset", live_o, 16'h0000);

        // R3 slow count wraps 49 to 0 through a full fast wrap
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'h3112);
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
        check("R3 slow wrap to zero", live_o, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule